// File: doc/BRIEF.md
# Max-RGB Pixel Histogram Collector

This block builds a per-frame histogram of pixel brightness from a video pixel stream. Each cycle may carry one pixel with three 8-bit colour channels. For every accepted pixel the block finds the largest of the red, green and blue values, keeps that value's five most significant bits as a bin number, and adds one to that bin's 32-bit pixel counter. There are 32 bins.

Frames are delimited by a start marker on the first pixel and an end marker on the last pixel. When the last pixel has been counted, the whole set of counters is copied into a readout bank in the same clock edge, and a one-cycle done pulse follows. A host then reads any bin through an index input and a data output. The readout bank keeps the last finished frame's results while the next frame accumulates. A global enable turns collection on and off.

Top module: `maxrgb_hist`

## Requirements
- R1: The bin index of a pixel is max(R,G,B) shifted right by 3, which is bits 7:3 of the largest channel. Bins are numbered 0 to 31.
- R2: Every cycle with `coll_en`=1 and `px_vld`=1 adds one to the counter of that pixel's bin. Cycles with `px_vld`=0 change no counter and raise no done, even when the marker inputs are high.
- R3: A pixel with `coll_en`=1, `px_vld`=1 and `px_first`=1 clears all 32 counters, and that pixel is then counted into its own bin. A start marker in the middle of a frame therefore discards the earlier pixels.
- R4: A frame made only of pure red pixels (255,0,0) leaves its full pixel count in bin 31 and zero in every other bin.
- R5: While `coll_en`=0, no counter changes. Pixels, start markers and end markers are ignored, no done pulse occurs, and the readout bank is left as it was.
- R6: A pixel with `coll_en`=1, `px_vld`=1 and `px_last`=1 copies all counters, including that pixel's count, into the readout bank. `hist_done` is high for exactly the next cycle.
- R7: `rd_data` shows the readout bank entry selected by `rd_bin` with no clock delay. It changes only in the cycle `hist_done` is high, so reads stay stable while the next frame accumulates.
- R8: A counter that holds all ones stays at all ones and does not wrap. The counter width is the parameter `CNT_W`, 32 by default.
- R9: After reset all counters and all readout entries are zero and `hist_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| coll_en | input | 1 | Collection enable |
| px_vld | input | 1 | Pixel present this cycle |
| px_first | input | 1 | Pixel is the first of a frame |
| px_last | input | 1 | Pixel is the last of a frame |
| px_r | input | 8 | Red channel |
| px_g | input | 8 | Green channel |
| px_b | input | 8 | Blue channel |
| rd_bin | input | 5 | Bin index to read |
| rd_data | output | 32 | Count of the selected bin in the last finished frame |
| hist_done | output | 1 | One-cycle pulse after a frame's results are captured |

## Verification
The bin mapping is tried with one mixed frame. In that frame the winning channel moves between red, green and blue, and values sit on either side of a multiple of 8 (7 and 8, 247 and 248). A wrong channel pick or a wrong shift therefore lands a count in a neighbouring bin. Further frames cover the following cases:
- pure red, which tests the single-bin extreme;
- a start marker in mid-frame, which separates clearing from plain accumulation;
- pixels offered while the block is disabled, which must leave the live counters untouched;
- a long frame on a narrow-counter instance, which separates saturation from wrap-around.

// File: rtl/hist_pkg.sv
package hist_pkg;
    localparam int CH_W_DEF     = 8;
    localparam int BIN_BITS_DEF = 5;
    localparam int CNT_W_DEF    = 32;

    function automatic logic [CH_W_DEF-1:0] max3(input logic [CH_W_DEF-1:0] a,
                                                 input logic [CH_W_DEF-1:0] b,
                                                 input logic [CH_W_DEF-1:0] c);
        logic [CH_W_DEF-1:0] m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction
endpackage

// File: rtl/hist_binsel.sv
module hist_binsel #(
    parameter int CH_W     = hist_pkg::CH_W_DEF,
    parameter int BIN_BITS = hist_pkg::BIN_BITS_DEF
) (
    input  logic [CH_W-1:0]     r,
    input  logic [CH_W-1:0]     g,
    input  logic [CH_W-1:0]     b,
    output logic [BIN_BITS-1:0] bin
);
    localparam int SHIFT = CH_W - BIN_BITS;

    logic [CH_W-1:0] peak;

    always_comb begin
        peak = (r > g) ? r : g;
        if (b > peak) peak = b;
        bin = peak[CH_W-1:SHIFT];
    end
endmodule

// File: rtl/hist_core.sv
module hist_core #(
    parameter int BIN_BITS = hist_pkg::BIN_BITS_DEF,
    parameter int CNT_W    = hist_pkg::CNT_W_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hit,
    input  logic                first,
    input  logic                last,
    input  logic [BIN_BITS-1:0] bin,
    input  logic [BIN_BITS-1:0] rd_bin,
    output logic [CNT_W-1:0]    rd_data,
    output logic                done
);
    localparam int NBINS = 1 << BIN_BITS;

    typedef struct packed {
        logic [NBINS-1:0][CNT_W-1:0] acc;
        logic [NBINS-1:0][CNT_W-1:0] bank;
        logic                        done;
    } state_t;

    state_t s_d, s_q;
    logic [CNT_W-1:0] acc_nxt [NBINS];

    generate
        for (genvar i = 0; i < NBINS; i++) begin : g_bin
            logic [CNT_W-1:0] base_w;
            logic             sel_w;
            assign base_w     = (hit && first) ? '0 : s_q.acc[i];
            assign sel_w      = hit && (bin == BIN_BITS'(i));
            assign acc_nxt[i] = (sel_w && (base_w != {CNT_W{1'b1}})) ? base_w + 1'b1 : base_w;
        end
    endgenerate

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < NBINS; i++) begin
            s_d.acc[i] = acc_nxt[i];
        end
        s_d.done = hit && last;
        if (hit && last) begin
            for (int i = 0; i < NBINS; i++) begin
                s_d.bank[i] = acc_nxt[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_data = s_q.bank[rd_bin];
    assign done    = s_q.done;
endmodule

// File: rtl/maxrgb_hist.sv
module maxrgb_hist #(
    parameter int CH_W     = hist_pkg::CH_W_DEF,
    parameter int BIN_BITS = hist_pkg::BIN_BITS_DEF,
    parameter int CNT_W    = hist_pkg::CNT_W_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                coll_en,
    input  logic                px_vld,
    input  logic                px_first,
    input  logic                px_last,
    input  logic [CH_W-1:0]     px_r,
    input  logic [CH_W-1:0]     px_g,
    input  logic [CH_W-1:0]     px_b,
    input  logic [BIN_BITS-1:0] rd_bin,
    output logic [CNT_W-1:0]    rd_data,
    output logic                hist_done
);
    logic                hit;
    logic [BIN_BITS-1:0] bin;

    assign hit = coll_en && px_vld;

    hist_binsel #(.CH_W(CH_W), .BIN_BITS(BIN_BITS)) u_sel (
        .r(px_r), .g(px_g), .b(px_b), .bin(bin)
    );

    hist_core #(.BIN_BITS(BIN_BITS), .CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .hit(hit), .first(px_first), .last(px_last),
        .bin(bin), .rd_bin(rd_bin), .rd_data(rd_data), .done(hist_done)
    );
endmodule

// File: rtl/maxrgb_hist_chk.sv
module maxrgb_hist_chk #(
    parameter int BIN_BITS = 5,
    parameter int CNT_W    = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                coll_en,
    input logic                px_vld,
    input logic                px_last,
    input logic [BIN_BITS-1:0] rd_bin,
    input logic [CNT_W-1:0]    rd_data,
    input logic                hist_done
);
    assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (coll_en && px_vld && px_last) |=> hist_done);

    assert_no_stray_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(coll_en && px_vld && px_last) |=> !hist_done);

    assert_read_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hist_done && $stable(rd_bin)) |-> $stable(rd_data));

    assert_read_known_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(rd_data) && !$isunknown(hist_done));
endmodule

bind maxrgb_hist maxrgb_hist_chk #(.BIN_BITS(BIN_BITS), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .coll_en(coll_en), .px_vld(px_vld), .px_last(px_last),
    .rd_bin(rd_bin), .rd_data(rd_data), .hist_done(hist_done)
);

// File: tb/sim_maxrgb_hist.sv
module sim_maxrgb_hist;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        coll_en = 1'b0;
    logic        px_vld = 1'b0;
    logic        px_first = 1'b0;
    logic        px_last = 1'b0;
    logic [7:0]  px_r = '0, px_g = '0, px_b = '0;
    logic [4:0]  rd_bin = '0;
    logic [31:0] rd_data;
    logic        hist_done;
    logic [3:0]  rd_data1;
    logic        hist_done1;

    int total = 0;
    int bad = 0;
    int exp_bin [32];
    bit finished = 1'b0;

    // each entry: {r, g, b, expected bin}
    localparam logic [31:0] TBL [16] = '{
        {8'd255, 8'd0,   8'd0,   8'd31}, {8'd0,   8'd0,   8'd0,   8'd0},
        {8'd7,   8'd7,   8'd7,   8'd0},  {8'd8,   8'd0,   8'd0,   8'd1},
        {8'd0,   8'd8,   8'd3,   8'd1},  {8'd0,   8'd0,   8'd255, 8'd31},
        {8'd16,  8'd200, 8'd100, 8'd25}, {8'd128, 8'd127, 8'd129, 8'd16},
        {8'd247, 8'd248, 8'd0,   8'd31}, {8'd0,   8'd120, 8'd119, 8'd15},
        {8'd63,  8'd64,  8'd65,  8'd8},  {8'd100, 8'd100, 8'd100, 8'd12},
        {8'd39,  8'd40,  8'd0,   8'd5},  {8'd0,   8'd0,   8'd23,  8'd2},
        {8'd255, 8'd255, 8'd255, 8'd31}, {8'd31,  8'd0,   8'd32,  8'd4}
    };

    always #2 clk = ~clk;

    maxrgb_hist u0 (
        .clk(clk), .rst_n(rst_n), .coll_en(coll_en), .px_vld(px_vld),
        .px_first(px_first), .px_last(px_last), .px_r(px_r), .px_g(px_g), .px_b(px_b),
        .rd_bin(rd_bin), .rd_data(rd_data), .hist_done(hist_done)
    );

    maxrgb_hist #(.CNT_W(4)) u1 (
        .clk(clk), .rst_n(rst_n), .coll_en(coll_en), .px_vld(px_vld),
        .px_first(px_first), .px_last(px_last), .px_r(px_r), .px_g(px_g), .px_b(px_b),
        .rd_bin(rd_bin), .rd_data(rd_data1), .hist_done(hist_done1)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic pix(input logic [7:0] r, g, b, input logic f, l);
        @(negedge clk);
        px_vld = 1'b1; px_first = f; px_last = l; px_r = r; px_g = g; px_b = b;
    endtask

    task automatic gap(input logic [7:0] r, g, b);
        @(negedge clk);
        px_vld = 1'b0; px_first = 1'b1; px_last = 1'b1; px_r = r; px_g = g; px_b = b;
    endtask

    task automatic idle();
        @(negedge clk);
        px_vld = 1'b0; px_first = 1'b0; px_last = 1'b0;
    endtask

    task automatic clear_model();
        for (int i = 0; i < 32; i++) exp_bin[i] = 0;
    endtask

    task automatic check_bins(input string req);
        for (int i = 0; i < 32; i++) begin
            rd_bin = 5'(i);
            #1;
            chk(rd_data == 32'(exp_bin[i]), req, rd_data, 32'(exp_bin[i]));
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        clear_model();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk(hist_done == 1'b0, "R9 done", 32'(hist_done), 0);
        check_bins("R9 bins");
        chk(rd_data1 == 4'd0, "R9 narrow", 32'(rd_data1), 0);

        // R1 R2 R6: table frame, with one invalid cycle that carries markers
        coll_en = 1'b1;
        for (int i = 0; i < 16; i++) begin
            if (i == 8) gap(8'd255, 8'd0, 8'd0);
            pix(TBL[i][31:24], TBL[i][23:16], TBL[i][15:8], i == 0, i == 15);
            exp_bin[TBL[i][4:0]]++;
        end
        idle();
        chk(hist_done == 1'b1, "R6 done pulse", 32'(hist_done), 1);
        idle();
        chk(hist_done == 1'b0, "R6 done one cycle", 32'(hist_done), 0);
        check_bins("R1 R2 table bins");

        // R7: next frame accumulates, readout unchanged
        for (int i = 0; i < 10; i++) pix(8'd255, 8'd0, 8'd0, i == 0, 1'b0);
        idle();
        chk(hist_done == 1'b0, "R7 no done mid-frame", 32'(hist_done), 0);
        check_bins("R7 stable readout");
        pix(8'd255, 8'd0, 8'd0, 1'b0, 1'b1);
        idle();
        chk(hist_done == 1'b1, "R4 done", 32'(hist_done), 1);
        clear_model();
        exp_bin[31] = 11;
        check_bins("R4 R3 pure red");

        // R5: disabled collection ignores everything
        coll_en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            pix(8'd0, 8'd40, 8'd0, 1'b1, 1'b1);
            idle();
            chk(hist_done == 1'b0, "R5 no done disabled", 32'(hist_done), 0);
        end
        check_bins("R5 bank kept");
        coll_en = 1'b1;
        pix(8'd255, 8'd0, 8'd0, 1'b0, 1'b1);
        idle();
        chk(hist_done == 1'b1, "R5 done after enable", 32'(hist_done), 1);
        exp_bin[31] = 12;
        check_bins("R5 counters untouched");

        // R3: start marker mid-frame discards earlier pixels
        for (int i = 0; i < 3; i++) pix(8'd0, 8'd0, 8'd16, i == 0, 1'b0);
        pix(8'd0, 8'd0, 8'd80, 1'b1, 1'b0);
        pix(8'd0, 8'd0, 8'd80, 1'b0, 1'b0);
        pix(8'd0, 8'd0, 8'd80, 1'b0, 1'b1);
        idle();
        clear_model();
        exp_bin[10] = 3;
        check_bins("R3 restart");

        // R8: saturation on narrow instance, wide one keeps counting
        for (int i = 0; i < 20; i++) pix(8'd24, 8'd0, 8'd0, i == 0, i == 19);
        idle();
        chk(hist_done1 == 1'b1, "R8 narrow done", 32'(hist_done1), 1);
        rd_bin = 5'd3;
        #1;
        chk(rd_data == 32'd20, "R8 wide count", rd_data, 20);
        chk(rd_data1 == 4'd15, "R8 saturated", 32'(rd_data1), 15);
        rd_bin = 5'd0;
        #1;
        chk(rd_data1 == 4'd0, "R8 other bin", 32'(rd_data1), 0);

        summary();
    end
endmodule